// File: doc/BRIEF.md
# Multiplier Timing Error Rate Harness

This block measures how often a full-rate 18x18 multiplier produces a wrong product. Two 48-bit linear feedback shift registers supply a new pseudo-random operand pair every enabled cycle. A fast pipeline multiplies each pair within a single clock period and re-registers the result through a stabilize stage. Two slow reference multipliers, A and B, run on opposite phases of a half-rate clock enable. Each reference holds its operands for two cycles, so between them they produce a trusted product for every pair.

The stabilized fast product is compared with the reference product of the same pair. Each inequality adds one to a wide, saturating error counter. On silicon, lowering the supply makes the fast path fail first, and the counter gives the error rate at that voltage. For test, an injection input flips one product bit, so the counting path can be exercised without a real timing failure.

Top module: `mul_err_harness`

## Requirements
- R1: Reset (synchronous, active high) clears the error count to zero, loads both shift registers with their non-zero seeds and clears every pipeline valid flag.
- R2: Each shift register advances one step per cycle while enable is high, with a maximal-length 48-bit feedback taken from state bits 47, 46, 20 and 19 (XOR, shift toward the MSB). It holds its state while enable is low and never reaches the all-zero state.
- R3: The fast path uses operand X = bits [17:0] of the first shift register and operand Y = bits [47:30] of the second. It registers the pair, then registers the 36-bit product, then passes it through one stabilize register before comparison.
- R4: A free-running phase bit toggles every cycle after reset, starting at 0. Reference A captures a pair on edges where the phase is 0 and reference B on edges where it is 1. Each registers its product two cycles after capture, so the pair compared in any cycle uses the reference selected by the pair's own phase.
- R5: Each mismatch between a valid stabilized fast product and its reference adds exactly one to the count, in the edge that follows the comparison cycle. A fault applied at edge k therefore shows in the count after edge k+2.
- R6: When fault_inj is high at the edge where a fast product is registered, bit 0 of that product is inverted.
- R7: The count changes only on edges where enable is high, and only for pairs that were launched on an edge where enable was high.
- R8: The count saturates at all ones and stays there.
- R9: With no fault injected the count stays at zero over any run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs stimulus and counting |
| fault_inj | input | 1 | Inverts bit 0 of the fast product being registered |
| err_count | output | CNT_W (40) | Saturating count of mismatches |

## Verification
On every cycle, the embedded assertions check four things. The shift registers never go to zero and freeze while enable is low. The phase alternates. The fast and reference products agree exactly when no fault rides with the pair and differ when one does. The count moves by at most one, freezes while enable is low and holds at saturation. The latency from a fault to the count, the exclusion of pairs launched or compared with enable low, and the restart after a reset in mid-run can only be seen in the bench's scenarios. The same is true of saturation in a narrow-counter instance and of long clean runs that stay at zero.

// File: rtl/mul_err_harness.sv
module mul_err_harness #(
  parameter int LFSR_W = 48,
  parameter int OP_W   = 18,
  parameter int CNT_W  = 40,
  parameter logic [LFSR_W-1:0] TAPS   = 48'hC000_0018_0000,
  parameter logic [LFSR_W-1:0] SEED_A = 48'h9E37_79B9_7F4A,
  parameter logic [LFSR_W-1:0] SEED_B = 48'h5A5A_C3D2_E1F0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             fault_inj,
  output logic [CNT_W-1:0] err_count
);
  localparam int PROD_W = 2 * OP_W;

  logic [LFSR_W-1:0] lfsr_a, lfsr_b;
  logic [OP_W-1:0]   opnd_x, opnd_y;
  logic              phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_a <= SEED_A;
      lfsr_b <= SEED_B;
    end else if (enable) begin
      lfsr_a <= {lfsr_a[LFSR_W-2:0], ^(lfsr_a & TAPS)};
      lfsr_b <= {lfsr_b[LFSR_W-2:0], ^(lfsr_b & TAPS)};
    end
  end

  assign opnd_x = lfsr_a[OP_W-1:0];
  assign opnd_y = lfsr_b[LFSR_W-1 -: OP_W];

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  // fast path: operand reg, product reg, stabilize reg
  logic [OP_W-1:0]   f_x, f_y;
  logic              f_v, f_t;
  logic [PROD_W-1:0] f_p;
  logic              f_pv, f_pt, f_pf;
  logic [PROD_W-1:0] s_p;
  logic              s_v, s_t, s_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_x <= '0; f_y <= '0; f_v <= 1'b0; f_t <= 1'b0;
      f_p <= '0; f_pv <= 1'b0; f_pt <= 1'b0; f_pf <= 1'b0;
      s_p <= '0; s_v <= 1'b0; s_t <= 1'b0; s_f <= 1'b0;
    end else begin
      f_x  <= opnd_x;
      f_y  <= opnd_y;
      f_v  <= enable;
      f_t  <= phase;
      f_p  <= (PROD_W'(f_x) * PROD_W'(f_y)) ^ PROD_W'(fault_inj);
      f_pv <= f_v;
      f_pt <= f_t;
      f_pf <= fault_inj;
      s_p  <= f_p;
      s_v  <= f_pv;
      s_t  <= f_pt;
      s_f  <= f_pf;
    end
  end

  // slow references: two-cycle multicycle paths on opposite phases
  logic [OP_W-1:0]   a_x, a_y, b_x, b_y;
  logic [PROD_W-1:0] a_p, b_p, ref_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_x <= '0; a_y <= '0; a_p <= '0;
    end else if (!phase) begin
      a_x <= opnd_x;
      a_y <= opnd_y;
      a_p <= PROD_W'(a_x) * PROD_W'(a_y);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_x <= '0; b_y <= '0; b_p <= '0;
    end else if (phase) begin
      b_x <= opnd_x;
      b_y <= opnd_y;
      b_p <= PROD_W'(b_x) * PROD_W'(b_y);
    end
  end

  assign ref_p = s_t ? b_p : a_p;

  logic mismatch;
  assign mismatch = s_v && (s_p != ref_p);

  always_ff @(posedge clk) begin
    if (rst)
      err_count <= '0;
    else if (enable && mismatch && (err_count != '1))
      err_count <= err_count + CNT_W'(1);
  end

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (lfsr_a != '0) && (lfsr_b != '0));
  // R2
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(lfsr_a) && $stable(lfsr_b));
  // R4
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    phase |=> !phase);
  // R5
  ref_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (s_v && !s_f) |-> (s_p == ref_p));
  // R6
  fault_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (s_v && s_f) |-> (s_p != ref_p));
  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(err_count) |=> (err_count == $past(err_count)) ||
                               (err_count == $past(err_count) + CNT_W'(1)));
  // R7
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(err_count));
  // R8
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (err_count == '1) |=> (err_count == '1));
endmodule

// File: tb/mul_err_harness_tb_top.sv
`timescale 1ns/1ps
module mul_err_harness_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        fault_inj = 1'b0;
  logic [39:0] cnt;
  logic [2:0]  cnt_s;

  always #2.5 clk = ~clk;

  mul_err_harness dut_i (
    .clk(clk), .rst(rst), .enable(enable), .fault_inj(fault_inj), .err_count(cnt));

  mul_err_harness #(.CNT_W(3)) dut_sat_i (
    .clk(clk), .rst(rst), .enable(enable), .fault_inj(fault_inj), .err_count(cnt_s));

  typedef struct {
    logic [39:0] c;
    logic [2:0]  s;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  bit          en_h[$];
  bit          f_h[$];
  int          n = 0;
  logic [39:0] exp_c = '0;
  logic [2:0]  exp_s = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  // driver: one cycle of stimulus, expected counts pushed for the coming edge
  task automatic step(input bit r, input bit e, input bit f, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; enable = e; fault_inj = f;
    if (r) begin
      n = 0; en_h.delete(); f_h.delete(); exp_c = '0; exp_s = '0;
    end else begin
      en_h.push_back(e);
      f_h.push_back(f);
      // R5 fault at edge k counts at k+2; R7 needs enable at launch and count edge
      if (n >= 3 && en_h[n-3] && f_h[n-2] && e) begin
        if (exp_c != '1) exp_c = exp_c + 40'd1;
        if (exp_s != 3'h7) exp_s = exp_s + 3'd1;
      end
      n++;
    end
    it.c = exp_c; it.s = exp_s; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: pops one item per edge and compares both instances
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0 && !done) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (cnt !== it.c) begin
        n_fail++;
        $display("FAIL %s: count actual %0d expected %0d", it.tag, cnt, it.c);
      end
      n_chk++;
      if (cnt_s !== it.s) begin
        n_fail++;
        $display("FAIL R8 (during %s): narrow count actual %0d expected %0d", it.tag, cnt_s, it.s);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R1");
    // R2 stepping with no fault: reference tracks the fast path
    for (int i = 0; i < 100; i++) step(0, 1, 0, "R2");
    // R3 / R4 alternating references over more pairs
    for (int i = 0; i < 100; i++) step(0, 1, 0, "R3");
    for (int i = 0; i < 100; i++) step(0, 1, 0, "R4");
    // R6 single injected faults, spaced apart
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 1, "R6");
      for (int i = 0; i < 6; i++) step(0, 1, 0, "R6");
    end
    // R5 burst of back-to-back faults on both phases
    for (int i = 0; i < 9; i++) step(0, 1, 1, "R5");
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R5");
    // R7 faults while enable is low, then toggling enable under faults
    for (int i = 0; i < 5; i++) step(0, 0, 0, "R7");
    for (int i = 0; i < 10; i++) step(0, 0, 1, "R7");
    for (int i = 0; i < 20; i++) step(0, i[0], 1, "R7");
    for (int i = 0; i < 20; i++) step(0, i[1], (i % 3) == 0, "R7");
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R7");
    // R1 reset in mid-run, then restart
    for (int i = 0; i < 2; i++) step(1, 1, 1, "R1");
    for (int i = 0; i < 5; i++) step(0, 1, 1, "R1");
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R1");
    // R8 long fault run drives the narrow counter into saturation
    for (int i = 0; i < 30; i++) step(0, 1, 1, "R8");
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R8");
    // R9 fresh start, long clean run stays at zero
    for (int i = 0; i < 2; i++) step(1, 0, 0, "R9");
    for (int i = 0; i < 600; i++) step(0, 1, 0, "R9");
    step(0, 0, 0, "R9");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule